// File: doc/BRIEF.md
# Pack Cell Imbalance Selector

This block looks at one complete set of cell voltage readings from a battery pack made of several modules. The readings arrive one cell per strobe. From each set it derives the pack average, the cell with the lowest voltage anywhere in the pack and the module with the highest total voltage. It also derives the largest distance of any cell from the average and a flag saying that the pack is balanced enough to stop. A balancing controller uses these results to route energy from the strongest module to the weakest cell. It feeds a fresh set after every measurement cycle. Because every set is judged from scratch, the choice moves to whichever cell is furthest behind as weak cells catch up.

Control is a two-state machine. `ST_COLLECT` accepts cells, updating running sums and extremes for each accepted cell. The transition `collect_to_eval` is taken when the accepted cell carries the frame-end marker. `ST_EVAL` lasts exactly one cycle: the results are registered, the accumulators are cleared and the transition `eval_to_collect` is taken unconditionally. Readings are checked against programmable under- and over-voltage limits. A bad reading, an external fault or a malformed set blocks any target choice.

Top module: `cell_balance_selector`

## Requirements
- R1: `res_valid` is a one-cycle pulse. It is high in the cycle after the clock edge that follows the edge sampling a strobed cell with `cell_last` high. All result outputs change only together with that pulse and hold otherwise.
- R2: `avg_mv` is the sum of the N = CELLS_PER_MOD × NUM_MODS cell values of the frame, divided by N with truncation toward zero.
- R3: `tgt_cell` is the global index of the lowest cell. Cells are numbered from 0 in arrival order, so module m holds indices m×CELLS_PER_MOD upward. `tgt_mod` is the module holding that cell. When several cells share the lowest value, the lowest index wins.
- R4: `src_mod` is the module whose CELLS_PER_MOD consecutive cells have the largest sum. When sums are equal, the lowest module index wins.
- R5: `max_dev_mv` is the largest absolute difference between any cell value and `avg_mv`.
- R6: `bal_done` is 1 exactly when `max_dev_mv` is strictly below `thresh_mv` and `fault` is 0.
- R7: `fault` is 1 when `fault_in` is high on any accepted cell, or when any cell is below `uv_mv` or above `ov_mv`. When `fault` is 1, `tgt_vld` and `bal_done` are 0; otherwise `tgt_vld` is 1.
- R8: `fault` is 1 when the frame carries fewer or more than N cells.
- R9: A strobe in the `ST_EVAL` cycle, the cycle right after the frame-end cell is sampled, is ignored. It neither contributes to the next frame nor ends a frame.
- R10: After reset, all outputs are 0. Each frame is evaluated independently of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cell_valid | input | 1 | Strobe for one cell reading |
| cell_mv | input | 16 | Cell voltage in millivolts |
| cell_last | input | 1 | Marks the final cell of the frame |
| fault_in | input | 1 | External fault indication, sampled with each cell |
| thresh_mv | input | 16 | Balance band half-width in millivolts |
| uv_mv | input | 16 | Under-voltage limit |
| ov_mv | input | 16 | Over-voltage limit |
| res_valid | output | 1 | One-cycle result pulse |
| avg_mv | output | 16 | Pack average |
| max_dev_mv | output | 16 | Largest deviation from the average |
| tgt_cell | output | 4 | Global index of the weakest cell |
| tgt_mod | output | 1 | Module of the weakest cell |
| src_mod | output | 1 | Strongest module |
| tgt_vld | output | 1 | Target choice is usable |
| bal_done | output | 1 | Pack is within the band |
| fault | output | 1 | Fault seen in this frame |

## Verification
Two kinds of collision are provoked. The first: when the final module is the strongest, its ranking update lands on the same edge as the frame close. A frame with a uniformly higher last module shows whether that late update reaches `src_mod`. The second: the evaluation cycle can coincide with a strobe that a producer sends too early. The bench strobes a zero-valued, frame-ending cell exactly in that cycle. It then judges the next frame by its ports: no fault and the reference results show the strobe was dropped.

// File: rtl/cba_pkg.sv
package cba_pkg;
    typedef enum logic [0:0] {
        ST_COLLECT = 1'b0,
        ST_EVAL    = 1'b1
    } cba_state_e;
endpackage

// File: rtl/cba_accum.sv
module cba_accum #(
    parameter int VW = 16,
    parameter int CPM = 7,
    parameter int NMOD = 2,
    localparam int N = CPM * NMOD,
    localparam int CIW = (N > 1) ? $clog2(N) : 1,
    localparam int MIW = (NMOD > 1) ? $clog2(NMOD) : 1,
    localparam int PW = (CPM > 1) ? $clog2(CPM) : 1,
    localparam int SW = VW + CIW + 1,
    localparam int MSW = VW + PW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           take,
    input  logic           last,
    input  logic           flt_in,
    input  logic [VW-1:0]  cell_mv,
    input  logic [VW-1:0]  uv_mv,
    input  logic [VW-1:0]  ov_mv,
    output logic [SW-1:0]  sum_o,
    output logic [VW-1:0]  min_o,
    output logic [VW-1:0]  max_o,
    output logic [CIW-1:0] min_idx_o,
    output logic [MIW-1:0] min_mod_o,
    output logic [MIW-1:0] src_mod_o,
    output logic           fault_o
);
    logic [SW-1:0]  sum_q;
    logic [VW-1:0]  min_q, max_q;
    logic [CIW-1:0] cnt_q, min_idx_q;
    logic [MIW-1:0] mod_q, min_mod_q, src_q;
    logic [PW-1:0]  pos_q;
    logic [MSW-1:0] run_q, best_q, run_n;
    logic           flt_q, first;

    assign run_n = run_q + MSW'(cell_mv);
    assign first = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            sum_q <= '0; min_q <= '0; max_q <= '0;
            cnt_q <= '0; min_idx_q <= '0; mod_q <= '0;
            min_mod_q <= '0; src_q <= '0; pos_q <= '0;
            run_q <= '0; best_q <= '0; flt_q <= 1'b0;
        end else if (take) begin
            sum_q <= sum_q + SW'(cell_mv);
            if (first || cell_mv < min_q) begin
                min_q     <= cell_mv;
                min_idx_q <= cnt_q;
                min_mod_q <= mod_q;
            end
            if (first || cell_mv > max_q) max_q <= cell_mv;
            if (pos_q == PW'(CPM - 1)) begin
                if (mod_q == '0 || run_n > best_q) begin
                    best_q <= run_n;
                    src_q  <= mod_q;
                end
                run_q <= '0;
                pos_q <= '0;
                if (mod_q != MIW'(NMOD - 1)) mod_q <= mod_q + 1'b1;
            end else begin
                run_q <= run_n;
                pos_q <= pos_q + 1'b1;
            end
            if (cnt_q == CIW'(N - 1)) begin
                if (!last) flt_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (last) flt_q <= 1'b1;
            end
            if (flt_in || cell_mv < uv_mv || cell_mv > ov_mv) flt_q <= 1'b1;
        end
    end

    assign sum_o     = sum_q;
    assign min_o     = min_q;
    assign max_o     = max_q;
    assign min_idx_o = min_idx_q;
    assign min_mod_o = min_mod_q;
    assign src_mod_o = src_q;
    assign fault_o   = flt_q;

    a_r3_min_not_above_max: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> (min_q <= max_q));
endmodule

// File: rtl/cba_eval.sv
module cba_eval #(
    parameter int VW = 16,
    parameter int N = 14,
    parameter int SW = 21
) (
    input  logic [SW-1:0] sum_i,
    input  logic [VW-1:0] min_i,
    input  logic [VW-1:0] max_i,
    input  logic [VW-1:0] thresh_i,
    output logic [VW-1:0] avg_o,
    output logic [VW-1:0] dev_o,
    output logic          within_o
);
    logic [SW-1:0] quot;
    logic [VW-1:0] dev_hi, dev_lo;

    always_comb begin
        quot     = sum_i / SW'(N);
        avg_o    = quot[VW-1:0];
        dev_hi   = max_i - avg_o;
        dev_lo   = avg_o - min_i;
        dev_o    = (dev_hi > dev_lo) ? dev_hi : dev_lo;
        within_o = (dev_o < thresh_i);
    end
endmodule

// File: rtl/cell_balance_selector.sv
module cell_balance_selector
    import cba_pkg::*;
#(
    parameter int VW = 16,
    parameter int CELLS_PER_MOD = 7,
    parameter int NUM_MODS = 2,
    localparam int N = CELLS_PER_MOD * NUM_MODS,
    localparam int CIW = (N > 1) ? $clog2(N) : 1,
    localparam int MIW = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1,
    localparam int SW = VW + CIW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cell_valid,
    input  logic [VW-1:0]  cell_mv,
    input  logic           cell_last,
    input  logic           fault_in,
    input  logic [VW-1:0]  thresh_mv,
    input  logic [VW-1:0]  uv_mv,
    input  logic [VW-1:0]  ov_mv,
    output logic           res_valid,
    output logic [VW-1:0]  avg_mv,
    output logic [VW-1:0]  max_dev_mv,
    output logic [CIW-1:0] tgt_cell,
    output logic [MIW-1:0] tgt_mod,
    output logic [MIW-1:0] src_mod,
    output logic           tgt_vld,
    output logic           bal_done,
    output logic           fault
);
    cba_state_e     state_q, state_d;
    logic           take, clr;
    logic [SW-1:0]  acc_sum;
    logic [VW-1:0]  acc_min, acc_max, ev_avg, ev_dev;
    logic [CIW-1:0] acc_min_idx;
    logic [MIW-1:0] acc_min_mod, acc_src;
    logic           acc_flt, ev_within;

    assign take = (state_q == ST_COLLECT) && cell_valid;
    assign clr  = (state_q == ST_EVAL);

    cba_accum #(.VW(VW), .CPM(CELLS_PER_MOD), .NMOD(NUM_MODS)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .last(cell_last),
        .flt_in(fault_in), .cell_mv(cell_mv), .uv_mv(uv_mv), .ov_mv(ov_mv),
        .sum_o(acc_sum), .min_o(acc_min), .max_o(acc_max),
        .min_idx_o(acc_min_idx), .min_mod_o(acc_min_mod),
        .src_mod_o(acc_src), .fault_o(acc_flt)
    );

    cba_eval #(.VW(VW), .N(N), .SW(SW)) u_eval (
        .sum_i(acc_sum), .min_i(acc_min), .max_i(acc_max), .thresh_i(thresh_mv),
        .avg_o(ev_avg), .dev_o(ev_dev), .within_o(ev_within)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (take && cell_last) state_d = ST_EVAL;
            ST_EVAL:    state_d = ST_COLLECT;
            default:    state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0; avg_mv <= '0; max_dev_mv <= '0;
            tgt_cell <= '0; tgt_mod <= '0; src_mod <= '0;
            tgt_vld <= 1'b0; bal_done <= 1'b0; fault <= 1'b0;
        end else begin
            res_valid <= (state_q == ST_EVAL);
            if (state_q == ST_EVAL) begin
                avg_mv     <= ev_avg;
                max_dev_mv <= ev_dev;
                tgt_cell   <= acc_min_idx;
                tgt_mod    <= acc_min_mod;
                src_mod    <= acc_src;
                fault      <= acc_flt;
                tgt_vld    <= !acc_flt;
                bal_done   <= ev_within && !acc_flt;
            end
        end
    end

    a_r1_eval_gives_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVAL) |=> res_valid);
    a_r1_pulse_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(cell_valid && cell_last, 2));
    a_r1_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(max_dev_mv) && $stable(tgt_cell) && $stable(src_mod)));
    a_r3_module_of_target: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && tgt_vld) |-> (int'(tgt_mod) == int'(tgt_cell) / CELLS_PER_MOD));
endmodule

// File: tb/cell_balance_selector_bench.sv
`timescale 1ns/1ps
module cell_balance_selector_bench;
    localparam int CPM = 7;
    localparam int NMOD = 2;
    localparam int N = CPM * NMOD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cell_valid = 1'b0, cell_last = 1'b0, fault_in = 1'b0;
    logic [15:0] cell_mv = '0;
    logic [15:0] thresh_mv = 16'd10, uv_mv = 16'd2500, ov_mv = 16'd4300;
    logic res_valid, tgt_vld, bal_done, fault;
    logic [15:0] avg_mv, max_dev_mv;
    logic [3:0] tgt_cell;
    logic [0:0] tgt_mod, src_mod;

    int checks = 0, errors = 0, cyc = 0, due = -10;
    int frm[$];
    int e_avg, e_dev, e_tc, e_tm, e_sm, e_done, e_flt;
    bit done_run = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cell_balance_selector u_cell_balance_selector (
        .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid), .cell_mv(cell_mv),
        .cell_last(cell_last), .fault_in(fault_in), .thresh_mv(thresh_mv),
        .uv_mv(uv_mv), .ov_mv(ov_mv), .res_valid(res_valid), .avg_mv(avg_mv),
        .max_dev_mv(max_dev_mv), .tgt_cell(tgt_cell), .tgt_mod(tgt_mod),
        .src_mod(src_mod), .tgt_vld(tgt_vld), .bal_done(bal_done), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Behavioural reference over the whole frame
    task automatic model(input int fpos);
        int s = 0, mn = 0, mx = 0, mi = 0, bs = -1, bm = 0, hi, lo;
        int n = frm.size();
        bit f = (fpos >= 0) || (n != N);
        for (int i = 0; i < n; i++) begin
            int v = frm[i];
            if (v < int'(uv_mv) || v > int'(ov_mv)) f = 1;
            s += v;
            if (i == 0 || v < mn) begin mn = v; mi = i; end
            if (i == 0 || v > mx) mx = v;
        end
        for (int m = 0; m < NMOD; m++) begin
            int ms = 0;
            for (int k = 0; k < CPM; k++)
                if (m * CPM + k < n) ms += frm[m * CPM + k];
            if (ms > bs) begin bs = ms; bm = m; end
        end
        e_avg = s / N;
        hi = mx - e_avg; lo = e_avg - mn;
        e_dev = (hi > lo) ? hi : lo;
        e_tc = mi; e_tm = mi / CPM; e_sm = bm; e_flt = f;
        e_done = (!f && e_dev < int'(thresh_mv)) ? 1 : 0;
    endtask

    task automatic send(input int fpos, input bit early_junk);
        model(fpos);
        for (int i = 0; i < frm.size(); i++) begin
            @(negedge clk);
            cell_valid = 1'b1; cell_mv = 16'(frm[i]);
            cell_last = (i == frm.size() - 1); fault_in = (i == fpos);
            if (cell_last) due = cyc + 2;
        end
        @(negedge clk);
        if (early_junk) begin
            cell_valid = 1'b1; cell_mv = 16'd0; cell_last = 1'b1; fault_in = 1'b1;
        end else begin
            cell_valid = 1'b0; cell_last = 1'b0; fault_in = 1'b0;
        end
        @(negedge clk);
        cell_valid = 1'b0; cell_last = 1'b0; fault_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic fill(input int base);
        frm.delete();
        for (int i = 0; i < N; i++) frm.push_back(base);
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            chk(res_valid == (cyc == due), "R1 res_valid timing", res_valid, cyc == due);
            if (cyc == due) begin
                chk(fault == e_flt, "R7/R8 fault", fault, e_flt);
                chk(tgt_vld == !e_flt, "R7 tgt_vld", tgt_vld, !e_flt);
                chk(bal_done == e_done, "R6 bal_done", bal_done, e_done);
                if (!e_flt) begin
                    chk(avg_mv == 16'(e_avg), "R2 average", avg_mv, e_avg);
                    chk(max_dev_mv == 16'(e_dev), "R5 deviation", max_dev_mv, e_dev);
                    chk(tgt_cell == 4'(e_tc), "R3 target cell", tgt_cell, e_tc);
                    chk(tgt_mod == 1'(e_tm), "R3 target module", tgt_mod, e_tm);
                    chk(src_mod == 1'(e_sm), "R4 source module", src_mod, e_sm);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid == 0 && avg_mv == 0 && max_dev_mv == 0 && tgt_cell == 0 && fault == 0
            && bal_done == 0 && tgt_vld == 0 && src_mod == 0, "R10 reset state", avg_mv, 0);
        rst_n = 1'b1;
        @(negedge clk);
        fill(4000); send(-1, 0);                                  // R6 balanced, R3/R4 ties
        fill(4000); frm[3] = 3950; for (int i = 7; i < N; i++) frm[i] = 4010;
        frm[9] = 3900; send(-1, 0);                               // R3 cross-module target
        fill(4000); frm[2] = 3800; frm[11] = 3800; send(-1, 0);   // R3 tie lowest index
        fill(4000); for (int i = 7; i < N; i++) frm[i] = 4100; send(-1, 0); // R4 last module
        fill(4000); frm[5] = 4012; send(-1, 0);                   // R6 above band
        fill(4000); frm[5] = 4009; send(-1, 0);                   // R6 inside band
        fill(4000); frm[12] = 3991; send(-1, 0);                  // R2 truncation, R5 low side
        thresh_mv = 16'd6;
        fill(4000); frm[0] = 4006; send(-1, 0);                   // R6 equal to threshold
        thresh_mv = 16'd10;
        fill(4000); frm[4] = 2000; send(-1, 0);                   // R7 under-voltage
        fill(4000); frm[8] = 4400; send(-1, 0);                   // R7 over-voltage
        fill(4000); send(6, 0);                                   // R7 external fault
        fill(4000); void'(frm.pop_back()); send(-1, 0);           // R8 short frame
        fill(4000); frm.push_back(4000); send(-1, 0);             // R8 long frame
        fill(3990); send(-1, 1);                                  // R9 strobe in eval cycle
        fill(4000); frm[10] = 3970; send(-1, 0);                  // R9/R10 next frame clean
        done_run = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule